// File: doc/BRIEF.md
# Sync Presence Detection and Vertical Source Selector

This block conditions the two raw sync inputs of a display deflection front end: a horizontal (or composite horizontal-plus-vertical) sync and a separate vertical sync. For each input it measures, once per fixed window of clock cycles, whether the line spends more time high than low. A mostly-high line is treated as active-low and is inverted, so that downstream logic always sees positive pulses. The conditioned composite line is also fed to a saturating up/down integrator. The integrator produces an extracted vertical pulse whenever a pulse lasts longer than a programmable threshold, which is set above the widest horizontal pulse.

Three sticky presence flags record that a pulse has been seen on the vertical input, on the composite input, and on the extracted vertical output. They are cleared together by a control write that has its clear bit set. The clear lands at that write's acknowledge strobe, and detection re-arms at once. The vertical output is taken either from the conditioned vertical input or from the extracted pulse. In manual mode a control write picks the source. In auto mode a two-state selector picks it from the flags: it moves to the only present source, and it holds its current choice when both sources or neither are present. Polarity correction runs in both modes and cannot be written.

States and transitions. Each presence flag is a state machine with two states. It moves from FLG_ARMED to FLG_CAUGHT on a rising edge of its conditioned input. It moves from FLG_CAUGHT back to FLG_ARMED on a clearing write. The selector has the states SRC_PURE and SRC_EXTR. A manual write moves it to the state named by the written select bit. In auto mode it moves from SRC_PURE to SRC_EXTR when only the extracted flag is set, and from SRC_EXTR to SRC_PURE when only the vertical flag is set. In every other case it stays where it is.

Top module: `sync_sel_top`

## Requirements
- R1: After reset, all three presence flags are 0, both polarity bits are 0, the selector is 0 (conditioned vertical input) and auto mode is 0.
- R2: A rising edge of a conditioned sync line sets that line's presence flag at the next clock edge. The flag then stays 1 until a clear, whatever the line does afterwards. The flags are flag_v for the vertical line, flag_hv for the composite line and flag_ext for the extracted pulse.
- R3: A write acknowledge (wr_ack=1) with wr_data bit 2 set clears all three flags at that clock edge. The clear wins over a rising edge in the same cycle. A later rising edge sets the flag again.
- R4: Each polarity bit is updated only at the clock edge that samples the last cycle of a WIN-cycle window counted from reset. It becomes 1 if more than half of that window's samples were high, and 0 otherwise (a tie gives 0). It holds its value between updates in either mode.
- R5: h_out equals hv_in XOR pol_hv, combinationally.
- R6: The integrator counts up by one per cycle when the conditioned composite line is high and down by one when it is low. It saturates at 0 and at 2^IW-1. vext_out is 1 while the count is at least ext_thresh.
- R7: A write acknowledge with wr_data bit 0 clear puts the selector to wr_data bit 1 at that edge (1 = extracted pulse).
- R8: In auto mode the selector moves to the extracted pulse when only flag_ext is set, and to the vertical input when only flag_v is set. It holds when both flags or neither are set. A written wr_data bit 1 has no effect while the write sets auto mode.
- R9: v_out is vext_out when the selector is 1, and the conditioned vertical line (v_in XOR pol_v) when it is 0.
- R10: Each write acknowledge loads auto_mode from wr_data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_in | input | 1 | Raw horizontal or composite sync |
| v_in | input | 1 | Raw separate vertical sync |
| wr_ack | input | 1 | Control write acknowledge strobe; the write takes effect at this edge |
| wr_data | input | 3 | Control bits: 0 auto mode, 1 manual select, 2 clear flags |
| ext_thresh | input | IW | Integrator threshold for vertical extraction |
| h_out | output | 1 | Positive-polarity horizontal sync |
| vext_out | output | 1 | Extracted vertical pulse |
| v_out | output | 1 | Selected positive vertical sync |
| pol_hv | output | 1 | Composite line inversion bit |
| pol_v | output | 1 | Vertical line inversion bit |
| flag_v | output | 1 | Sticky vertical presence flag |
| flag_hv | output | 1 | Sticky composite presence flag |
| flag_ext | output | 1 | Sticky extracted-vertical presence flag |
| vsel | output | 1 | Vertical source select (0 vertical input, 1 extracted) |
| auto_mode | output | 1 | Auto selection enabled |

## Verification
The polarity path is swept over every high-sample count from 0 to WIN within an aligned window, with complementary counts on the two inputs. This separates the strict-majority rule from a tie, and the update edge from the cycles before it. The extractor is driven with isolated pulses of every width from 1 to 12 against a fixed threshold, which shows the exact cycle where vexp rises and whether a short pulse sets the extracted flag. A long pulse followed by a decay exposes the saturation limit. Flag and selector sequences combine single-source, dual-source and no-source flag states, clears that coincide with a rising edge, and writes made while in auto mode. Together these distinguish hysteresis from last-writer behaviour.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;

    // control word bit positions (host write port)
    localparam int CTL_AUTO = 0;
    localparam int CTL_VSEL = 1;
    localparam int CTL_CLR  = 2;
    localparam int CTL_W    = 3;

    typedef enum logic {
        SRC_PURE = 1'b0,
        SRC_EXTR = 1'b1
    } vsrc_e;

    typedef enum logic {
        FLG_ARMED  = 1'b0,
        FLG_CAUGHT = 1'b1
    } flag_st_e;

endpackage

// File: rtl/sync_pol_meas.sv
module sync_pol_meas #(
    parameter int WIN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic pol
);
    localparam int CW = $clog2(WIN);
    localparam int AW = $clog2(WIN + 1) + 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);
    localparam logic signed [AW-1:0] ONE = AW'(1);

    logic [CW-1:0]        cnt;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] acc_nx;
    logic                 mostly_high;

    always_comb begin
        acc_nx      = raw_in ? acc + ONE : acc - ONE;
        mostly_high = !acc_nx[AW-1] && (acc_nx != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            acc <= '0;
            pol <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            acc <= '0;
            pol <= mostly_high;
        end else begin
            cnt <= cnt + CW'(1);
            acc <= acc_nx;
        end
    end

    // R4: polarity only moves at the window boundary
    a_r4_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST) |=> $stable(pol));

    // R4: accumulator restarts each window
    a_r4_acc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (acc == '0));

endmodule

// File: rtl/sync_presence_flag.sv
module sync_presence_flag
    import sync_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic clr,
    output logic flag
);
    flag_st_e state;
    flag_st_e state_nx;
    logic     prev;
    logic     rise;

    assign rise = sig & ~prev;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FLG_ARMED;
            prev  <= 1'b1;
        end else begin
            state <= state_nx;
            prev  <= sig;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            FLG_ARMED:  if (!clr && rise) state_nx = FLG_CAUGHT;
            FLG_CAUGHT: if (clr)          state_nx = FLG_ARMED;
            default:                      state_nx = FLG_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        flag = (state == FLG_CAUGHT);
    end

    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    a_r2_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !clr) |=> flag);

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);

endmodule

// File: rtl/sync_v_extract.sv
module sync_v_extract #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hv_pos,
    input  logic [IW-1:0] thresh,
    output logic          vext
);
    localparam logic [IW-1:0] MAXV = '1;

    logic [IW-1:0] integ;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
        end else if (hv_pos) begin
            if (integ != MAXV) integ <= integ + IW'(1);
        end else begin
            if (integ != '0) integ <= integ - IW'(1);
        end
    end

    always_comb begin
        vext = (integ >= thresh);
    end

    a_r6_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (integ == MAXV && hv_pos) |=> (integ == MAXV));

    a_r6_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (integ == '0 && !hv_pos) |=> (integ == '0));

    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_pos && integ != MAXV) |=> (integ == $past(integ) + IW'(1)));

endmodule

// File: rtl/sync_src_select.sv
module sync_src_select
    import sync_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic host_wr,
    input  logic host_sel,
    input  logic have_v,
    input  logic have_ext,
    output logic sel
);
    vsrc_e state;
    vsrc_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SRC_PURE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (host_wr) begin
            state_nx = host_sel ? SRC_EXTR : SRC_PURE;
        end else if (auto_en) begin
            unique case (state)
                SRC_PURE: if (have_ext && !have_v) state_nx = SRC_EXTR;
                SRC_EXTR: if (have_v && !have_ext) state_nx = SRC_PURE;
                default:                           state_nx = SRC_PURE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sel = (state == SRC_EXTR);
    end

    a_r8_hold_both: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !host_wr && have_v && have_ext) |=> $stable(sel));

    a_r8_hold_none: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !host_wr && !have_v && !have_ext) |=> $stable(sel));

    a_r8_only_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !host_wr && have_ext && !have_v) |=> sel);

    a_r8_only_v: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !host_wr && have_v && !have_ext) |=> !sel);

    a_r7_manual: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (sel == $past(host_sel)));

endmodule

// File: rtl/sync_sel_top.sv
module sync_sel_top
    import sync_sel_pkg::*;
#(
    parameter int WIN = 32,
    parameter int IW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_in,
    input  logic              v_in,
    input  logic              wr_ack,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic [IW-1:0]     ext_thresh,
    output logic              h_out,
    output logic              vext_out,
    output logic              v_out,
    output logic              pol_hv,
    output logic              pol_v,
    output logic              flag_v,
    output logic              flag_hv,
    output logic              flag_ext,
    output logic              vsel,
    output logic              auto_mode
);
    logic hv_pos;
    logic v_pos;
    logic clr_all;
    logic host_wr;

    // polarity measurement, one per input line
    sync_pol_meas #(.WIN(WIN)) u_pol_hv (
        .clk(clk), .rst_n(rst_n), .raw_in(hv_in), .pol(pol_hv)
    );
    sync_pol_meas #(.WIN(WIN)) u_pol_v (
        .clk(clk), .rst_n(rst_n), .raw_in(v_in), .pol(pol_v)
    );

    assign hv_pos = hv_in ^ pol_hv;
    assign v_pos  = v_in ^ pol_v;
    assign h_out  = hv_pos;

    sync_v_extract #(.IW(IW)) u_extract (
        .clk(clk), .rst_n(rst_n), .hv_pos(hv_pos),
        .thresh(ext_thresh), .vext(vext_out)
    );

    // control write decode
    assign clr_all = wr_ack & wr_data[CTL_CLR];
    assign host_wr = wr_ack & ~wr_data[CTL_AUTO];

    always_ff @(posedge clk) begin
        if (!rst_n)      auto_mode <= 1'b0;
        else if (wr_ack) auto_mode <= wr_data[CTL_AUTO];
    end

    sync_presence_flag u_flag_v (
        .clk(clk), .rst_n(rst_n), .sig(v_pos), .clr(clr_all), .flag(flag_v)
    );
    sync_presence_flag u_flag_hv (
        .clk(clk), .rst_n(rst_n), .sig(hv_pos), .clr(clr_all), .flag(flag_hv)
    );
    sync_presence_flag u_flag_ext (
        .clk(clk), .rst_n(rst_n), .sig(vext_out), .clr(clr_all), .flag(flag_ext)
    );

    sync_src_select u_select (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_mode),
        .host_wr(host_wr), .host_sel(wr_data[CTL_VSEL]),
        .have_v(flag_v), .have_ext(flag_ext), .sel(vsel)
    );

    assign v_out = vsel ? vext_out : v_pos;

    a_r10_auto_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> (auto_mode == $past(wr_data[CTL_AUTO])));

    a_r10_auto_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ack |=> $stable(auto_mode));

    a_r3_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (!flag_v && !flag_hv && !flag_ext));

endmodule

// File: tb/sync_sel_top_test.sv
`timescale 1ns/1ps
module sync_sel_top_test;
    localparam int WIN = 32;
    localparam int IW  = 4;
    localparam int T   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hv_in = 1'b0, v_in = 1'b0, wr_ack = 1'b0;
    logic [2:0] wr_data = '0;
    logic [IW-1:0] ext_thresh = IW'(T);
    logic h_out, vext_out, v_out, pol_hv, pol_v;
    logic flag_v, flag_hv, flag_ext, vsel, auto_mode;

    int vecs = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    sync_sel_top #(.WIN(WIN), .IW(IW)) uut (
        .clk(clk), .rst_n(rst_n), .hv_in(hv_in), .v_in(v_in),
        .wr_ack(wr_ack), .wr_data(wr_data), .ext_thresh(ext_thresh),
        .h_out(h_out), .vext_out(vext_out), .v_out(v_out),
        .pol_hv(pol_hv), .pol_v(pol_v), .flag_v(flag_v), .flag_hv(flag_hv),
        .flag_ext(flag_ext), .vsel(vsel), .auto_mode(auto_mode)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hv_in = 1'b0; v_in = 1'b0; wr_ack = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write(input logic [2:0] d);
        wr_data = d; wr_ack = 1'b1;
        step();
        wr_ack = 1'b0;
    endtask

    task automatic hv_pulse(input int w);
        hv_in = 1'b1; step(w);
        hv_in = 1'b0; step(20);
    endtask

    task automatic v_pulse();
        v_in = 1'b1; step(3);
        v_in = 1'b0; step(5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk(flag_v, 1'b0, "R1 flag_v");
        chk(flag_hv, 1'b0, "R1 flag_hv");
        chk(flag_ext, 1'b0, "R1 flag_ext");
        chk(pol_hv, 1'b0, "R1 pol_hv");
        chk(pol_v, 1'b0, "R1 pol_v");
        chk(vsel, 1'b0, "R1 vsel");
        chk(auto_mode, 1'b0, "R1 auto_mode");

        // R4 / R5 polarity sweep over every high count in one window
        for (int k = 0; k <= WIN; k++) begin
            do_reset();
            for (int i = 0; i < WIN; i++) begin
                hv_in = (i < k);
                v_in  = (i < WIN - k);
                step();
                if (i == WIN - 2) begin
                    chk(pol_hv, 1'b0, "R4 hold before window end");
                    chk(pol_v, 1'b0, "R4 hold before window end (v)");
                end
            end
            chk(pol_hv, (2 * k > WIN), "R4 pol_hv majority");
            chk(pol_v, (2 * (WIN - k) > WIN), "R4 pol_v majority");
            hv_in = 1'b0; #0.5;
            chk(h_out, (2 * k > WIN), "R5 h_out low input");
            hv_in = 1'b1; #0.5;
            chk(h_out, !(2 * k > WIN), "R5 h_out high input");
        end

        // R6 extraction width sweep
        for (int w = 1; w <= 12; w++) begin
            do_reset();
            step(2);
            hv_in = 1'b1;
            for (int j = 1; j <= w; j++) begin
                step();
                chk(vext_out, (j >= T), "R6 vext during pulse");
            end
            hv_in = 1'b0;
            step(20);
            chk(flag_ext, (w >= T), "R6 extracted flag vs width");
            chk(flag_hv, 1'b1, "R2 composite flag set");
        end

        // R6 saturation then decay
        do_reset();
        step(2);
        hv_in = 1'b1; step(16);
        hv_in = 1'b0;
        for (int d = 1; d <= 12; d++) begin
            step();
            chk(vext_out, ((15 - d) >= T), "R6 saturated decay");
        end

        // R2 / R3 flag set, stickiness, clear, clear-vs-rise, re-arm
        do_reset();
        step(2);
        v_in = 1'b1; step();
        chk(flag_v, 1'b1, "R2 flag_v next edge");
        v_in = 1'b0; step(5);
        chk(flag_v, 1'b1, "R2 flag_v sticky");
        write(3'b100);
        chk(flag_v, 1'b0, "R3 clear flag_v");
        v_in = 1'b1; wr_data = 3'b100; wr_ack = 1'b1;
        step();
        wr_ack = 1'b0;
        chk(flag_v, 1'b0, "R3 clear wins over rise");
        step(2);
        chk(flag_v, 1'b0, "R3 no rise while held high");
        v_in = 1'b0; step();
        v_in = 1'b1; step();
        chk(flag_v, 1'b1, "R3 re-armed");
        v_in = 1'b0; step(3);
        hv_pulse(6);
        chk(flag_ext, 1'b1, "R2 flag_ext set");
        write(3'b100);
        chk(flag_v, 1'b0, "R3 all clear v");
        chk(flag_hv, 1'b0, "R3 all clear hv");
        chk(flag_ext, 1'b0, "R3 all clear ext");

        // R7 / R9 / R10 manual selection and output mux
        do_reset();
        step(2);
        write(3'b010);
        chk(vsel, 1'b1, "R7 manual select extracted");
        chk(auto_mode, 1'b0, "R10 auto off");
        hv_in = 1'b1; step(6);
        v_in = 1'b0; #0.5;
        chk(v_out, 1'b1, "R9 v_out follows extracted");
        hv_in = 1'b0; step(20);
        write(3'b000);
        chk(vsel, 1'b0, "R7 manual select vertical");
        v_in = 1'b1; #0.5;
        chk(v_out, 1'b1, "R9 v_out follows vertical");
        step();
        v_in = 1'b0; step(5);

        // R8 auto selection with hysteresis
        write(3'b101);
        chk(auto_mode, 1'b1, "R10 auto on");
        step(2);
        chk(vsel, 1'b0, "R8 hold with no flags");
        hv_pulse(6);
        chk(vsel, 1'b1, "R8 only extracted selects extracted");
        write(3'b001);
        step(2);
        chk(vsel, 1'b1, "R8 select bit ignored in auto");
        v_pulse();
        chk(vsel, 1'b1, "R8 both present holds extracted");
        write(3'b101);
        step(2);
        chk(vsel, 1'b1, "R8 hold after clear");
        v_pulse();
        chk(vsel, 1'b0, "R8 only vertical selects vertical");
        hv_pulse(6);
        chk(vsel, 1'b0, "R8 both present holds vertical");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule